// File: doc/BRIEF.md
# Interrupt Capture Status Register

This block is a bank of hardware-written status fields. Each field has its own capture behaviour, fixed by a parameter. Every clock cycle a field takes in its hardware input and updates its stored bits according to that behaviour. The behaviours are:

- level capture, which accumulates any set input bit;
- first-value capture, which latches a whole non-zero input word once;
- edge capture on rising, falling or both edges, either accumulating or pulsing for one cycle.

Edge detection compares the input against a registered copy of it taken on the previous cycle.

The stored bits drive two summary lines, an interrupt line and a halt line. For each line, a per-field qualifier kind is fixed by a parameter. A field can feed a line unqualified, gated by an enable vector, or gated by an inverted mask vector.

Software clears bits with a write-one-to-clear strobe vector. Hardware can also zero a whole field at once, and that hardware clear has the highest priority.

Top module: `irq_status_reg`

## Requirements
- R1: While `rst` is high at a clock edge, every field value and every registered input copy becomes zero, and `field_q`, `irq` and `halt` then read zero.
- R2: A level field (mode code 0) loads `(value & ~clear) | input` each cycle, where `clear` is that field's slice of `sw_clr`.
- R3: A first-value field (mode code 1) first forms `base = value & ~clear`. It loads the whole input when `base` is zero and the input is non-zero; otherwise it loads `base`.
- R4: Edge events are computed per bit against the input registered on the previous cycle, `prev`. A rising event is `~prev & input`, a falling event is `prev & ~input`, and a both-edge event is `prev ^ input`. `prev` follows the input every cycle, whatever the field does.
- R5: The accumulating edge fields load `(value & ~clear) | event`. Their mode codes are 2 for rising, 3 for falling and 4 for both edges.
- R6: The pulsing edge fields load the event vector every cycle, so each edge shows as a one-cycle pulse and `sw_clr` has no effect on them. Their mode codes are 5 for rising, 6 for falling and 7 for both edges.
- R7: When `hw_clr[i]` is high, field i loads zero on that edge, whatever its input or strobe.
- R8: When a field bit is both cleared by `sw_clr` and set by an input or event in the same cycle, the bit ends set.
- R9: `irq` is the OR over all fields of that field's contribution, with qualifier code 0, 1 or 2 per field. Code 0 contributes the reduction OR of the value. Code 1 contributes the reduction OR of `value & enable`. Code 2 contributes the reduction OR of `value & ~mask`.
- R10: `halt` is formed as in R9, using the halt qualifier codes and the `halt_en` and `halt_mask` vectors. It is combinational from the stored values and those vectors.
- R11: Field i occupies bits `[i*FIELD_W +: FIELD_W]` of every vector port. Its mode code is `FIELD_MODES[3*i +: 3]` and its qualifier codes are `INTR_QUAL[2*i +: 2]` and `HALT_QUAL[2*i +: 2]`. Qualifier code 3 acts as code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_in | input | NUM_FIELDS*FIELD_W | Hardware input for every field |
| hw_clr | input | NUM_FIELDS | Per-field hardware clear, highest priority |
| sw_clr | input | NUM_FIELDS*FIELD_W | Write-one-to-clear strobes |
| intr_en | input | NUM_FIELDS*FIELD_W | Interrupt enable bits (qualifier code 1) |
| intr_mask | input | NUM_FIELDS*FIELD_W | Interrupt mask bits (qualifier code 2) |
| halt_en | input | NUM_FIELDS*FIELD_W | Halt enable bits (qualifier code 1) |
| halt_mask | input | NUM_FIELDS*FIELD_W | Halt mask bits (qualifier code 2) |
| field_q | output | NUM_FIELDS*FIELD_W | Stored field values |
| irq | output | 1 | Aggregated interrupt line |
| halt | output | 1 | Aggregated halt line |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around its rising edge. They also assume that the mode and qualifier parameters stay fixed, so each field's properties can be chosen at elaboration. The stimulus changes all inputs only on the falling edge. It holds the enable and mask vectors steady for each cycle in which the outputs are compared. It combines toggling inputs, software strobes and hardware clears in the same cycles, so the priority rules are exercised without ever presenting an input that changes between edges.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int MODE_BITS = 3;
    localparam int QUAL_BITS = 2;

    typedef enum logic [MODE_BITS-1:0] {
        CAP_LEVEL   = 3'd0,
        CAP_FIRST   = 3'd1,
        CAP_RISE_ST = 3'd2,
        CAP_FALL_ST = 3'd3,
        CAP_BOTH_ST = 3'd4,
        CAP_RISE_PL = 3'd5,
        CAP_FALL_PL = 3'd6,
        CAP_BOTH_PL = 3'd7
    } capture_mode_e;

    typedef enum logic [QUAL_BITS-1:0] {
        QUAL_NONE = 2'd0,
        QUAL_EN   = 2'd1,
        QUAL_MASK = 2'd2,
        QUAL_RSVD = 2'd3
    } qual_kind_e;

    function automatic bit is_edge_mode(capture_mode_e m);
        return m >= CAP_RISE_ST;
    endfunction

    function automatic bit is_pulse_mode(capture_mode_e m);
        return m >= CAP_RISE_PL;
    endfunction

    function automatic bit is_accum_mode(capture_mode_e m);
        return (m == CAP_LEVEL) || (is_edge_mode(m) && !is_pulse_mode(m));
    endfunction

endpackage

// File: rtl/irq_field.sv
module irq_field import irq_pkg::*; #(
    parameter int            WIDTH = 4,
    parameter capture_mode_e MODE  = CAP_LEVEL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] hw_in,
    input  logic             hw_clr,
    input  logic [WIDTH-1:0] sw_clr,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] in_q;
    logic [WIDTH-1:0] evt;
    logic [WIDTH-1:0] base;
    logic [WIDTH-1:0] nxt;

    generate
        if (is_edge_mode(MODE)) begin : g_edge
            always_ff @(posedge clk) begin
                if (rst) in_q <= '0;
                else     in_q <= hw_in;
            end
        end else begin : g_level
            assign in_q = '0;
        end
    endgenerate

    always_comb begin
        unique case (MODE)
            CAP_RISE_ST, CAP_RISE_PL: evt = ~in_q & hw_in;
            CAP_FALL_ST, CAP_FALL_PL: evt = in_q & ~hw_in;
            default:                  evt = in_q ^ hw_in;
        endcase
    end

    always_comb begin
        base = value & ~sw_clr;
        unique case (MODE)
            CAP_LEVEL:   nxt = base | hw_in;
            CAP_FIRST:   nxt = ((base == '0) && (hw_in != '0)) ? hw_in : base;
            CAP_RISE_ST,
            CAP_FALL_ST,
            CAP_BOTH_ST: nxt = base | evt;
            default:     nxt = evt;
        endcase
        if (hw_clr) nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= nxt;
    end

    p_hwclr_wins_r7: assert property (@(posedge clk) disable iff (rst)
        hw_clr |=> (value == '0));

    generate
        if (MODE == CAP_FIRST) begin : g_chk_first
            p_first_hold_r3: assert property (@(posedge clk) disable iff (rst)
                (!hw_clr && sw_clr == '0 && value != '0) |=> $stable(value));
        end
        if (is_accum_mode(MODE)) begin : g_chk_accum
            p_accum_keep_r5: assert property (@(posedge clk) disable iff (rst)
                (!hw_clr && sw_clr == '0) |=> ((value & $past(value)) == $past(value)));
        end
        if (is_pulse_mode(MODE) && MODE == CAP_RISE_PL) begin : g_chk_rise
            p_pulse_rise_r6: assert property (@(posedge clk) disable iff (rst)
                !hw_clr |=> (value == (~$past(in_q) & $past(hw_in))));
        end
        if (MODE == CAP_BOTH_PL) begin : g_chk_both
            p_pulse_both_r6: assert property (@(posedge clk) disable iff (rst)
                !hw_clr |=> (value == ($past(in_q) ^ $past(hw_in))));
        end
    endgenerate

endmodule

// File: rtl/irq_reduce.sv
module irq_reduce import irq_pkg::*; #(
    parameter int                                NUM   = 8,
    parameter int                                WIDTH = 4,
    parameter logic [NUM*QUAL_BITS-1:0]          QUALS = '0
) (
    input  logic [NUM*WIDTH-1:0] fields,
    input  logic [NUM*WIDTH-1:0] en,
    input  logic [NUM*WIDTH-1:0] mask,
    output logic                 line
);

    logic [NUM-1:0] contrib;

    for (genvar i = 0; i < NUM; i++) begin : g_fld
        localparam qual_kind_e Q = qual_kind_e'(QUALS[i*QUAL_BITS +: QUAL_BITS]);
        always_comb begin
            unique case (Q)
                QUAL_EN:   contrib[i] = |(fields[i*WIDTH +: WIDTH] & en[i*WIDTH +: WIDTH]);
                QUAL_MASK: contrib[i] = |(fields[i*WIDTH +: WIDTH] & ~mask[i*WIDTH +: WIDTH]);
                default:   contrib[i] = |fields[i*WIDTH +: WIDTH];
            endcase
        end
    end

    assign line = |contrib;

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg import irq_pkg::*; #(
    parameter int                                 NUM_FIELDS  = 8,
    parameter int                                 FIELD_W     = 4,
    parameter logic [NUM_FIELDS*MODE_BITS-1:0]    FIELD_MODES = 24'hFAC688,
    parameter logic [NUM_FIELDS*QUAL_BITS-1:0]    INTR_QUAL   = 16'h4924,
    parameter logic [NUM_FIELDS*QUAL_BITS-1:0]    HALT_QUAL   = 16'h9249
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_FIELDS*FIELD_W-1:0] hw_in,
    input  logic [NUM_FIELDS-1:0]         hw_clr,
    input  logic [NUM_FIELDS*FIELD_W-1:0] sw_clr,
    input  logic [NUM_FIELDS*FIELD_W-1:0] intr_en,
    input  logic [NUM_FIELDS*FIELD_W-1:0] intr_mask,
    input  logic [NUM_FIELDS*FIELD_W-1:0] halt_en,
    input  logic [NUM_FIELDS*FIELD_W-1:0] halt_mask,
    output logic [NUM_FIELDS*FIELD_W-1:0] field_q,
    output logic                          irq,
    output logic                          halt
);

    localparam int VEC_W = NUM_FIELDS * FIELD_W;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam capture_mode_e M = capture_mode_e'(FIELD_MODES[i*MODE_BITS +: MODE_BITS]);
        irq_field #(
            .WIDTH (FIELD_W),
            .MODE  (M)
        ) u_field (
            .clk    (clk),
            .rst    (rst),
            .hw_in  (hw_in[i*FIELD_W +: FIELD_W]),
            .hw_clr (hw_clr[i]),
            .sw_clr (sw_clr[i*FIELD_W +: FIELD_W]),
            .value  (field_q[i*FIELD_W +: FIELD_W])
        );
    end

    irq_reduce #(
        .NUM   (NUM_FIELDS),
        .WIDTH (FIELD_W),
        .QUALS (INTR_QUAL)
    ) u_irq_or (
        .fields (field_q),
        .en     (intr_en),
        .mask   (intr_mask),
        .line   (irq)
    );

    irq_reduce #(
        .NUM   (NUM_FIELDS),
        .WIDTH (FIELD_W),
        .QUALS (HALT_QUAL)
    ) u_halt_or (
        .fields (field_q),
        .en     (halt_en),
        .mask   (halt_mask),
        .line   (halt)
    );

    p_irq_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (field_q == '0) |-> !irq);

    p_halt_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (field_q == '0) |-> !halt);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (field_q == {VEC_W{1'b0}}));

endmodule

// File: tb/test_irq_status_reg.sv
module test_irq_status_reg;

    localparam int NF = 8;
    localparam int FW = 4;
    localparam int VW = NF * FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [VW-1:0] hw_in = '0, sw_clr = '0;
    logic [NF-1:0] hw_clr = '0;
    logic [VW-1:0] intr_en = '0, intr_mask = '0, halt_en = '0, halt_mask = '0;
    logic [VW-1:0] field_q;
    logic          irq, halt;

    always #4 clk = ~clk;

    // R11: field i uses mode code i, interrupt qualifier i%3, halt qualifier (i+1)%3
    irq_status_reg #(
        .NUM_FIELDS  (NF),
        .FIELD_W     (FW),
        .FIELD_MODES (24'hFAC688),
        .INTR_QUAL   (16'h4924),
        .HALT_QUAL   (16'h9249)
    ) i_irq_status_reg (
        .clk(clk), .rst(rst), .hw_in(hw_in), .hw_clr(hw_clr), .sw_clr(sw_clr),
        .intr_en(intr_en), .intr_mask(intr_mask), .halt_en(halt_en), .halt_mask(halt_mask),
        .field_q(field_q), .irq(irq), .halt(halt)
    );

    typedef struct {
        logic [VW-1:0] f;
        logic          irq;
        logic          halt;
        int            tg [NF];
    } exp_t;

    exp_t    sb[$];
    int      total = 0;
    int      bad = 0;
    logic [FW-1:0] m_val  [NF];
    logic [FW-1:0] m_prev [NF];

    function automatic string tag_name(int t);
        case (t)
            2: return "R2";
            3: return "R3";
            5: return "R5 R4";
            6: return "R6 R4";
            7: return "R7";
            8: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic qual_or(int q, logic [FW-1:0] v, logic [FW-1:0] e, logic [FW-1:0] m);
        if (q == 1) return |(v & e);
        if (q == 2) return |(v & ~m);
        return |v;
    endfunction

    task automatic check1(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // driver: called on a falling edge, applies inputs, predicts, advances
    task automatic step(input logic [VW-1:0] hin, input logic [NF-1:0] hc, input logic [VW-1:0] sc);
        exp_t e;
        hw_in = hin; hw_clr = hc; sw_clr = sc;
        e.irq = 1'b0; e.halt = 1'b0;
        for (int i = 0; i < NF; i++) begin
            logic [FW-1:0] x, s, ev, b, n;
            x = hin[i*FW +: FW];
            s = sc[i*FW +: FW];
            case (i)
                2, 5:    ev = ~m_prev[i] & x;
                3, 6:    ev = m_prev[i] & ~x;
                default: ev = m_prev[i] ^ x;
            endcase
            b = m_val[i] & ~s;
            case (i)
                0:       n = b | x;
                1:       n = (b == '0 && x != '0) ? x : b;
                2, 3, 4: n = b | ev;
                default: n = ev;
            endcase
            if (hc[i]) n = '0;
            if (hc[i])                  e.tg[i] = 7;
            else if (s != '0 && i < 5)  e.tg[i] = 8;
            else if (i == 0)            e.tg[i] = 2;
            else if (i == 1)            e.tg[i] = 3;
            else if (i < 5)             e.tg[i] = 5;
            else                        e.tg[i] = 6;
            m_prev[i] = x;
            m_val[i]  = n;
            e.f[i*FW +: FW] = n;
            e.irq  |= qual_or(i % 3, n, intr_en[i*FW +: FW], intr_mask[i*FW +: FW]);
            e.halt |= qual_or((i + 1) % 3, n, halt_en[i*FW +: FW], halt_mask[i*FW +: FW]);
        end
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares one expected item per cycle, after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                for (int i = 0; i < NF; i++)
                    check1(tag_name(e.tg[i]), 32'(field_q[i*FW +: FW]), 32'(e.f[i*FW +: FW]));
                check1("R9", 32'(irq), 32'(e.irq));
                check1("R10", 32'(halt), 32'(e.halt));
            end
        end
    end

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NF; i++) begin m_val[i] = '0; m_prev[i] = '0; end
        hw_in = '1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state after edges with reset high and input held high
        check1("R1", field_q, '0);
        check1("R1", 32'(irq), 0);
        check1("R1", 32'(halt), 0);
        intr_en = '1; halt_en = '1;
        // R4: input already high, edge copy must be zero after reset -> rise events
        step('1, '0, '0);
        step('1, '0, '0);
        step('0, '0, '0);
        step('0, '0, '0);
        // back-to-back toggles
        for (int k = 0; k < 6; k++) step((k % 2) ? '0 : '1, '0, '0);
        // R3: first non-zero value kept, later values ignored
        step('0, '0, '1);
        step({NF{4'h5}}, '0, '0);
        step({NF{4'hA}}, '0, '0);
        step('0, '0, '0);
        // R8: clear coincides with events
        step({NF{4'h3}}, '0, '1);
        step({NF{4'hC}}, '0, {NF{4'hF}});
        // R7: hardware clear against events and strobes
        step({NF{4'h3}}, '1, '1);
        step({NF{4'hF}}, 8'h55, '0);
        // R9/R10 qualifier variations
        intr_en = '0; intr_mask = '1; halt_en = '0; halt_mask = '1;
        step({NF{4'h1}}, '0, '0);
        intr_mask = {NF{4'hE}}; halt_en = {NF{4'h1}};
        step({NF{4'h1}}, '0, '0);
        step('0, '0, '1);
        step('0, '0, '0);
        // mixed random traffic
        for (int k = 0; k < 800; k++) begin
            logic [VW-1:0] hin, sc;
            logic [NF-1:0] hc;
            if (k % 50 == 0) begin
                intr_en = $urandom; intr_mask = $urandom;
                halt_en = $urandom; halt_mask = $urandom;
            end
            hin = $urandom;
            hc  = (($urandom % 8) == 0) ? 8'($urandom) : '0;
            sc  = (($urandom % 3) == 0) ? VW'($urandom) : '0;
            step(hin, hc, sc);
        end
        step('0, '0, '0);
        @(negedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule